// File: doc/BRIEF.md
# Deep-Sleep Pad Output Override

This block stands between the peripheral output sources and the output pads of a chip. It serves two pad groups: the multiplexed pads and the dedicated pads. When the chip is awake, each pad's output value and output enable follow whatever peripheral source drives that pad. When the chip is in deep sleep, each pad instead drives a value that software chose in advance. That value is one of: forced low, forced high, or floating with the output enable released. A pad can also be set to keep its normal value during sleep. A pad marked as fed by an always-on peripheral is never overridden, so that peripheral can keep signalling while the rest of the chip sleeps.

Software programs each pad through a write port before it requests sleep. One write covers one pad: it carries a pad index and a 3-bit word holding a 2-bit sleep mode and an always-on flag. The deep-sleep request is captured by a two-state machine, `PWR_AWAKE` and `PWR_ASLEEP`. Transition `ENTER_SLEEP` goes from `PWR_AWAKE` to `PWR_ASLEEP` on a clock edge that samples the request high. Transition `WAKE` goes back on a clock edge that samples it low. Because the state is registered, the pads switch between normal and override values only on a clock edge.

Top module: `sleep_pad_ctrl`

## Requirements
- R1: After reset, every pad has sleep mode "keep" and no pad is marked always-on, so every pad output and output enable equal their source even while in deep sleep.
- R2: While the registered sleep state is awake, each pad output and output enable equal the pad's source output and source enable in the same cycle.
- R3: In sleep, a pad that is not always-on with mode 2'b00 drives output 0 with the enable high, and with mode 2'b01 drives output 1 with the enable high.
- R4: In sleep, a pad that is not always-on with mode 2'b10 floats: the enable is low and the output is 0.
- R5: In sleep, a pad with mode 2'b11 keeps passing its source output and source enable.
- R6: A pad whose always-on flag is set passes its source through in sleep, whatever its mode.
- R7: `deep_sleep_i` is sampled on the rising clock edge. The override starts after the edge that first samples it high and ends after the edge that first samples it low. Before that edge, the pads keep their previous behaviour.
- R8: A write with `cfg_we_i` high selects a pad with `cfg_idx_i`. Indices 0 to NUM_MIO-1 select multiplexed pads. Indices NUM_MIO to NUM_MIO+NUM_DIO-1 select dedicated pads (dedicated pad j is index NUM_MIO+j). Bits `cfg_wdata_i[1:0]` set the mode and bit `cfg_wdata_i[2]` sets the always-on flag. The write takes effect from the edge that samples it, including while in sleep.
- R9: A write whose index is NUM_MIO+NUM_DIO or more changes no pad's configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_sleep_i | input | 1 | Deep-sleep request, sampled on the clock edge |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Pad index of the write |
| cfg_wdata_i | input | 3 | {always-on flag, mode[1:0]} |
| mio_src_out_i | input | NUM_MIO | Source output value of each multiplexed pad |
| mio_src_oe_i | input | NUM_MIO | Source output enable of each multiplexed pad |
| dio_src_out_i | input | NUM_DIO | Source output value of each dedicated pad |
| dio_src_oe_i | input | NUM_DIO | Source output enable of each dedicated pad |
| mio_pad_out_o | output | NUM_MIO | Output value to multiplexed pads |
| mio_pad_oe_o | output | NUM_MIO | Output enable to multiplexed pads |
| dio_pad_out_o | output | NUM_DIO | Output value to dedicated pads |
| dio_pad_oe_o | output | NUM_DIO | Output enable to dedicated pads |

## Verification
The assertions assume that `deep_sleep_i`, `cfg_we_i`, `cfg_idx_i` and `cfg_wdata_i` are stable around each rising edge. They also assume that source values change only between edges, because the pad paths are combinational from the sources. The stimulus respects this by changing every input just after the falling edge and checking one nanosecond later. The stimulus also writes the configuration while asleep, writes out-of-range indices, and toggles the sleep request on its own. This exercises the corners where the registered state and the raw request differ.

// File: rtl/sleep_pad_pkg.sv
package sleep_pad_pkg;

    // Per-pad sleep behaviour, 2-bit code
    typedef enum logic [1:0] {
        SLP_DRIVE_LO = 2'b00,
        SLP_DRIVE_HI = 2'b01,
        SLP_FLOAT    = 2'b10,
        SLP_KEEP     = 2'b11
    } sleep_mode_e;

    // Configuration word of one pad: {always-on, mode}
    typedef struct packed {
        logic        aon;
        sleep_mode_e mode;
    } pad_cfg_t;

    localparam int unsigned CFG_W = $bits(pad_cfg_t);

    localparam pad_cfg_t PAD_CFG_RESET = '{aon: 1'b0, mode: SLP_KEEP};

    typedef enum logic {
        PWR_AWAKE  = 1'b0,
        PWR_ASLEEP = 1'b1
    } pwr_state_e;

endpackage

// File: rtl/sleep_pad_fsm.sv
module sleep_pad_fsm
    import sleep_pad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic deep_sleep_i,
    output logic sleep_active_o
);

    pwr_state_e state_q;
    pwr_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWR_AWAKE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: ENTER_SLEEP and WAKE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_AWAKE:  if (deep_sleep_i)  state_d = PWR_ASLEEP;
            PWR_ASLEEP: if (!deep_sleep_i) state_d = PWR_AWAKE;
            default:    state_d = PWR_AWAKE;
        endcase
    end

    // Outputs
    always_comb begin
        sleep_active_o = 1'b0;
        unique case (state_q)
            PWR_AWAKE:  sleep_active_o = 1'b0;
            PWR_ASLEEP: sleep_active_o = 1'b1;
            default:    sleep_active_o = 1'b0;
        endcase
    end

    AST_SLEEP_ENTERS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep_i |=> sleep_active_o); // R7

    AST_SLEEP_EXITS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !deep_sleep_i |=> !sleep_active_o); // R7

endmodule

// File: rtl/sleep_pad_cfg_regs.sv
module sleep_pad_cfg_regs
    import sleep_pad_pkg::*;
#(
    parameter int unsigned NUM_PADS = 12,
    parameter int unsigned IDX_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we_i,
    input  logic [IDX_W-1:0]           cfg_idx_i,
    input  logic [CFG_W-1:0]           cfg_wdata_i,
    output pad_cfg_t [NUM_PADS-1:0]    cfg_o
);

    pad_cfg_t [NUM_PADS-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PADS; p++) begin
                cfg_q[p] <= PAD_CFG_RESET;
            end
        end else if (cfg_we_i) begin
            for (int p = 0; p < NUM_PADS; p++) begin
                if (cfg_idx_i == IDX_W'(p)) begin
                    cfg_q[p] <= pad_cfg_t'(cfg_wdata_i);
                end
            end
        end
    end

    assign cfg_o = cfg_q;

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_wr_chk
        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we_i && cfg_idx_i == IDX_W'(g)) |=>
                (CFG_W'(cfg_q[g]) == $past(cfg_wdata_i))); // R8
    end

    AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_idx_i >= IDX_W'(NUM_PADS)) |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/sleep_pad_override.sv
module sleep_pad_override
    import sleep_pad_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep_i,
    input  pad_cfg_t cfg_i,
    input  logic     src_out_i,
    input  logic     src_oe_i,
    output logic     pad_out_o,
    output logic     pad_oe_o
);

    always_comb begin
        pad_out_o = src_out_i;
        pad_oe_o  = src_oe_i;
        if (sleep_i && !cfg_i.aon) begin
            unique case (cfg_i.mode)
                SLP_DRIVE_LO: begin pad_out_o = 1'b0; pad_oe_o = 1'b1; end
                SLP_DRIVE_HI: begin pad_out_o = 1'b1; pad_oe_o = 1'b1; end
                SLP_FLOAT:    begin pad_out_o = 1'b0; pad_oe_o = 1'b0; end
                SLP_KEEP:     begin pad_out_o = src_out_i; pad_oe_o = src_oe_i; end
                default:      begin pad_out_o = src_out_i; pad_oe_o = src_oe_i; end
            endcase
        end
    end

    AST_AWAKE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |-> (pad_out_o == src_out_i && pad_oe_o == src_oe_i)); // R2

    AST_DRIVE_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !cfg_i.aon && cfg_i.mode == SLP_DRIVE_HI) |-> (pad_out_o && pad_oe_o)); // R3

    AST_FLOAT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !cfg_i.aon && cfg_i.mode == SLP_FLOAT) |-> !pad_oe_o); // R4

    AST_AON_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.aon |-> (pad_out_o == src_out_i && pad_oe_o == src_oe_i)); // R6

endmodule

// File: rtl/sleep_pad_ctrl.sv
module sleep_pad_ctrl
    import sleep_pad_pkg::*;
#(
    parameter int unsigned NUM_MIO = 8,
    parameter int unsigned NUM_DIO = 4,
    localparam int unsigned NUM_PADS = NUM_MIO + NUM_DIO,
    localparam int unsigned IDX_W    = $clog2(NUM_PADS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               deep_sleep_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [2:0]         cfg_wdata_i,
    input  logic [NUM_MIO-1:0] mio_src_out_i,
    input  logic [NUM_MIO-1:0] mio_src_oe_i,
    input  logic [NUM_DIO-1:0] dio_src_out_i,
    input  logic [NUM_DIO-1:0] dio_src_oe_i,
    output logic [NUM_MIO-1:0] mio_pad_out_o,
    output logic [NUM_MIO-1:0] mio_pad_oe_o,
    output logic [NUM_DIO-1:0] dio_pad_out_o,
    output logic [NUM_DIO-1:0] dio_pad_oe_o
);

    logic                    sleep_active;
    pad_cfg_t [NUM_PADS-1:0] pad_cfg;

    sleep_pad_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .deep_sleep_i   (deep_sleep_i),
        .sleep_active_o (sleep_active)
    );

    sleep_pad_cfg_regs #(
        .NUM_PADS (NUM_PADS),
        .IDX_W    (IDX_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we_i),
        .cfg_idx_i   (cfg_idx_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_o       (pad_cfg)
    );

    for (genvar m = 0; m < NUM_MIO; m++) begin : g_mio
        sleep_pad_override u_ovr (
            .clk       (clk),
            .rst_n     (rst_n),
            .sleep_i   (sleep_active),
            .cfg_i     (pad_cfg[m]),
            .src_out_i (mio_src_out_i[m]),
            .src_oe_i  (mio_src_oe_i[m]),
            .pad_out_o (mio_pad_out_o[m]),
            .pad_oe_o  (mio_pad_oe_o[m])
        );
    end

    for (genvar d = 0; d < NUM_DIO; d++) begin : g_dio
        sleep_pad_override u_ovr (
            .clk       (clk),
            .rst_n     (rst_n),
            .sleep_i   (sleep_active),
            .cfg_i     (pad_cfg[NUM_MIO + d]),
            .src_out_i (dio_src_out_i[d]),
            .src_oe_i  (dio_src_oe_i[d]),
            .pad_out_o (dio_pad_out_o[d]),
            .pad_oe_o  (dio_pad_oe_o[d])
        );
    end

    AST_RESET_KEEPS_SOURCES: assert property (@(posedge clk)
        !rst_n |-> (mio_pad_out_o == mio_src_out_i && dio_pad_oe_o == dio_src_oe_i)); // R1

endmodule

// File: tb/sleep_pad_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_pad_ctrl_tb;

    localparam int NM = 8;
    localparam int ND = 4;
    localparam int NP = NM + ND;
    localparam int IW = $clog2(NP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          deep_sleep = 1'b0;
    logic          we = 1'b0;
    logic [IW-1:0] idx = '0;
    logic [2:0]    wdata = '0;
    logic [NM-1:0] mio_so = '0, mio_se = '0;
    logic [ND-1:0] dio_so = '0, dio_se = '0;
    logic [NM-1:0] mio_po, mio_pe;
    logic [ND-1:0] dio_po, dio_pe;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int model_mode [NP];
    bit model_aon  [NP];
    bit model_sleep;

    always #2.5 clk = ~clk;

    sleep_pad_ctrl #(.NUM_MIO(NM), .NUM_DIO(ND)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .deep_sleep_i  (deep_sleep),
        .cfg_we_i      (we),
        .cfg_idx_i     (idx),
        .cfg_wdata_i   (wdata),
        .mio_src_out_i (mio_so),
        .mio_src_oe_i  (mio_se),
        .dio_src_out_i (dio_so),
        .dio_src_oe_i  (dio_se),
        .mio_pad_out_o (mio_po),
        .mio_pad_oe_o  (mio_pe),
        .dio_pad_out_o (dio_po),
        .dio_pad_oe_o  (dio_pe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_sleep <= 1'b0;
            for (int i = 0; i < NP; i++) begin
                model_mode[i] <= 3;
                model_aon[i]  <= 1'b0;
            end
        end else begin
            model_sleep <= deep_sleep;
            if (we && int'(idx) < NP) begin
                model_mode[int'(idx)] <= int'(wdata[1:0]);
                model_aon[int'(idx)]  <= wdata[2];
            end
        end
    end

    function automatic string case_tag(int p);
        if (!model_sleep)           return "R2";
        if (model_aon[p])           return "R6";
        if (model_mode[p] == 2)     return "R4";
        if (model_mode[p] == 3)     return "R5";
        return "R3";
    endfunction

    task automatic check_pads(input string phase);
        for (int p = 0; p < NP; p++) begin
            bit so, se, eo, ee, ao, ae;
            if (p < NM) begin
                so = mio_so[p]; se = mio_se[p]; ao = mio_po[p]; ae = mio_pe[p];
            end else begin
                so = dio_so[p-NM]; se = dio_se[p-NM]; ao = dio_po[p-NM]; ae = dio_pe[p-NM];
            end
            eo = so; ee = se;
            if (model_sleep && !model_aon[p]) begin
                case (model_mode[p])
                    0: begin eo = 1'b0; ee = 1'b1; end
                    1: begin eo = 1'b1; ee = 1'b1; end
                    2: begin eo = 1'b0; ee = 1'b0; end
                    default: ;
                endcase
            end
            vectors++;
            if (ao !== eo || ae !== ee) begin
                miscompares++;
                $display("FAIL %s/%s pad %0d out/oe actual %b/%b expected %b/%b",
                         case_tag(p), phase, p, ao, ae, eo, ee);
            end
        end
    endtask

    task automatic step(input bit sl, input bit w, input int i, input logic [2:0] d,
                        input string phase);
        @(negedge clk);
        deep_sleep = sl;
        we         = w;
        idx        = IW'(i);
        wdata      = d;
        mio_so     = NM'($urandom);
        mio_se     = NM'($urandom);
        dio_so     = ND'($urandom);
        dio_se     = ND'($urandom);
        #1;
        check_pads(phase);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then sleep with default configuration
        for (int c = 0; c < 3; c++) step(1'b0, 1'b0, 0, 3'b0, "R1");
        @(negedge clk); rst_n = 1'b1;
        for (int c = 0; c < 10; c++) step(1'b1, 1'b0, 0, 3'b0, "R1");
        step(1'b0, 1'b0, 0, 3'b0, "R7");
        step(1'b0, 1'b0, 0, 3'b0, "R7");
        // R8: program every pad while awake, dedicated pads included
        for (int p = 0; p < NP; p++) step(1'b0, 1'b1, p, {(p % 5 == 0), 2'(p % 4)}, "R8");
        // R7: enter sleep, first checked cycle still awake
        for (int c = 0; c < 20; c++) step(1'b1, 1'b0, 0, 3'b0, "R7");
        // R8: reprogram during sleep
        for (int p = 0; p < NP; p++) step(1'b1, 1'b1, p, {(p % 3 == 1), 2'((p + 1) % 4)}, "R8");
        // R9: out-of-range indices change nothing
        for (int i = NP; i < (1 << IW); i++) step(1'b1, 1'b1, i, 3'(i), "R9");
        for (int c = 0; c < 4; c++) step(1'b1, 1'b0, 0, 3'b0, "R9");
        // R2: wake up, pass-through
        for (int c = 0; c < 20; c++) step(1'b0, 1'b0, 0, 3'b0, "R2");
        // Mixed traffic
        for (int c = 0; c < 400; c++)
            step(($urandom % 4) != 0, ($urandom % 3) == 0, int'($urandom % (1 << IW)),
                 3'($urandom), "RND");
        // Toggle every cycle around edges
        for (int c = 0; c < 20; c++) step(c[0], 1'b0, 0, 3'b0, "R7");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule